// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Programmed Threshold Flags

This block is a 64-word by 36-bit first-in first-out buffer that joins two unrelated clock domains. Port A writes on its own clock and port B reads on its own clock. Each pointer crosses into the other domain as Gray code through a two-flop synchronizer. Each side therefore sees exact status for its own pointer and a slightly late, always safe view of the other side.

Four active-low status outputs report the fill state. The write domain drives full and almost-full. The read domain drives empty and almost-empty. The threshold used by both almost flags is one of four preset distances, picked by a two-bit select input. That select is captured only at the instant reset is released.

Reset is a single active-low input that may change at any time relative to either clock. It must be held low for at least four rising edges of each clock. Once reset is released, the full flag stays low for two more write-clock edges before the buffer admits data. The read data port drives its bus only when selected for a read. The bus itself is given as a value plus an output-enable for pads elsewhere on the chip.

Top module: `dual_clock_fifo`

## Requirements
- R1: While rstN is low, fullN, emptyN and almostEmptyN are 0, almostFullN is 1, and bData is 0.
- R2: After rstN rises, fullN is still 0 after the first rising wrClk edge and becomes 1 after the second.
- R3: The threshold is captured on the rising edge of rstN as 4 × (flagSel + 1): code 00 gives 4, 01 gives 8, 10 gives 12 and 11 gives 16. Changes to flagSel after that edge have no effect on the flags.
- R4: A word is stored on a rising wrClk edge only when all of these hold: aCsN=0, aWrSel=1, aEn=1, aMbSel=0 and fullN=1. Any other combination stores nothing.
- R5: A word is read on a rising rdClk edge only when all of these hold: bCsN=0, bWrSel=0, bEn=1, bMbSel=0 and emptyN=1. The read word appears on bData after that edge, and bData holds its value otherwise.
- R6: Words leave in the order they were written, and all 64 locations are usable.
- R7: fullN is 0 exactly when 64 words are held as counted in the write domain. A write attempted while full is discarded.
- R8: emptyN is 0 exactly when no word is held as counted in the read domain. A read attempted while empty leaves bData unchanged.
- R9: almostFullN is 0 when the free space seen in the write domain is at or below the threshold.
- R10: almostEmptyN is 0 when the word count seen in the read domain is at or below the threshold.
- R11: bDataOe is 1 exactly when bCsN=0 and bWrSel=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Port A (write) clock |
| rdClk | input | 1 | Port B (read) clock |
| rstN | input | 1 | Asynchronous active-low reset; its rising edge captures flagSel |
| flagSel | input | 2 | Threshold select for the almost flags |
| aCsN | input | 1 | Port A select, active low |
| aWrSel | input | 1 | Port A direction, 1 = write |
| aEn | input | 1 | Port A enable |
| aMbSel | input | 1 | Port A side-register select; must be 0 to write the buffer |
| aData | input | 36 | Write data |
| bCsN | input | 1 | Port B select, active low |
| bWrSel | input | 1 | Port B direction, 0 = read |
| bEn | input | 1 | Port B enable |
| bMbSel | input | 1 | Port B side-register select; must be 0 to read the buffer |
| bData | output | 36 | Last word read |
| bDataOe | output | 1 | Drive enable for the port B data pads |
| fullN | output | 1 | Full flag, active low, write domain |
| almostFullN | output | 1 | Almost-full flag, active low, write domain |
| emptyN | output | 1 | Empty flag, active low, read domain |
| almostEmptyN | output | 1 | Almost-empty flag, active low, read domain |

## Verification
The properties take several things for granted about the inputs:
- Reset is held low across at least two edges of each clock, so the two-edge release delay on fullN can be judged from sampled reset history.
- flagSel is steady around the rising edge of rstN.
- Control inputs change away from the rising edge of the clock that samples them.

The stimulus meets these conditions in the following ways:
- Write-side inputs change only on falling wrClk edges, and read-side inputs only on falling rdClk edges.
- Reset is held for five edges of each clock.
- rstN is released on a falling wrClk edge, which the chosen clock periods never align with a rising rdClk edge.
- flagSel is moved to a different code only after the release, which exposes any late capture.

// File: rtl/dual_clock_fifo_pkg.sv
package dual_clock_fifo_pkg;

  typedef struct packed {
    logic wrStrobe;
    logic rdStrobe;
  } fifoStrobes_t;

endpackage

// File: rtl/dual_clock_fifo_gray_sync.sv
module dual_clock_fifo_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] grayIn,
  output logic [W-1:0] grayOut
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      grayOut <= '0;
    end else begin
      stage1  <= grayIn;
      grayOut <= stage1;
    end
  end

endmodule

// File: rtl/dual_clock_fifo_datapath.sv
module dual_clock_fifo_datapath
  import dual_clock_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] storage [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrStrobe) storage[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                 rdData <= '0;
    else if (strobes.rdStrobe) rdData <= storage[rdAddr];
  end

endmodule

// File: rtl/dual_clock_fifo_ctrl.sv
module dual_clock_fifo_ctrl
  import dual_clock_fifo_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int SEL_W       = 2,
  parameter int OFFSET_STEP = 4,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  flagSel,
  input  logic              aCsN,
  input  logic              aWrSel,
  input  logic              aEn,
  input  logic              aMbSel,
  input  logic              bCsN,
  input  logic              bWrSel,
  input  logic              bEn,
  input  logic              bMbSel,
  output fifoStrobes_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [PTR_W-1:0]  wrLevel,
  output logic [PTR_W-1:0]  rdLevel,
  output logic              fullN,
  output logic              almostFullN,
  output logic              emptyN,
  output logic              almostEmptyN
);

  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Threshold captured at the release edge of reset
  logic [PTR_W-1:0] offsetReg;
  always_ff @(posedge rstN) begin
    offsetReg <= PTR_W'((int'(flagSel) + 1) * OFFSET_STEP);
  end

  // ---------------- write domain ----------------
  logic [1:0]       wrReadyPipe;
  logic [PTR_W-1:0] wrPtrBin, wrPtrGray, wrPtrNext;
  logic [PTR_W-1:0] rdGraySync, rdPtrSyncBin, freeSpace;
  logic             wrReady, wrAccept;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) wrReadyPipe <= '0;
    else       wrReadyPipe <= {wrReadyPipe[0], 1'b1};
  end
  assign wrReady = wrReadyPipe[1];

  dual_clock_fifo_gray_sync #(.W(PTR_W)) u_rdPtrSync (
    .clk(wrClk), .rstN(rstN), .grayIn(rdPtrGray), .grayOut(rdGraySync)
  );

  assign rdPtrSyncBin = grayToBin(rdGraySync);
  assign wrLevel      = wrPtrBin - rdPtrSyncBin;
  assign freeSpace    = DEPTH_P - wrLevel;
  assign fullN        = wrReady && (wrLevel != DEPTH_P);
  assign almostFullN  = !wrReady || (freeSpace > offsetReg);
  assign wrAccept     = !aCsN && aWrSel && aEn && !aMbSel && fullN;
  assign wrPtrNext    = wrPtrBin + PTR_W'(wrAccept);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtrBin  <= '0;
      wrPtrGray <= '0;
    end else begin
      wrPtrBin  <= wrPtrNext;
      wrPtrGray <= wrPtrNext ^ (wrPtrNext >> 1);
    end
  end

  // ---------------- read domain ----------------
  logic [1:0]       rdReadyPipe;
  logic [PTR_W-1:0] rdPtrBin, rdPtrGray, rdPtrNext;
  logic [PTR_W-1:0] wrGraySync, wrPtrSyncBin;
  logic             rdReady, rdAccept;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) rdReadyPipe <= '0;
    else       rdReadyPipe <= {rdReadyPipe[0], 1'b1};
  end
  assign rdReady = rdReadyPipe[1];

  dual_clock_fifo_gray_sync #(.W(PTR_W)) u_wrPtrSync (
    .clk(rdClk), .rstN(rstN), .grayIn(wrPtrGray), .grayOut(wrGraySync)
  );

  assign wrPtrSyncBin = grayToBin(wrGraySync);
  assign rdLevel      = wrPtrSyncBin - rdPtrBin;
  assign emptyN       = rdReady && (rdLevel != '0);
  assign almostEmptyN = rdReady && (rdLevel > offsetReg);
  assign rdAccept     = !bCsN && !bWrSel && bEn && !bMbSel && emptyN;
  assign rdPtrNext    = rdPtrBin + PTR_W'(rdAccept);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdPtrBin  <= '0;
      rdPtrGray <= '0;
    end else begin
      rdPtrBin  <= rdPtrNext;
      rdPtrGray <= rdPtrNext ^ (rdPtrNext >> 1);
    end
  end

  assign strobes.wrStrobe = wrAccept;
  assign strobes.rdStrobe = rdAccept;
  assign wrAddr = wrPtrBin[ADDR_W-1:0];
  assign rdAddr = rdPtrBin[ADDR_W-1:0];

endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo
  import dual_clock_fifo_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int DEPTH       = 64,
  parameter int SEL_W       = 2,
  parameter int OFFSET_STEP = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  flagSel,
  input  logic              aCsN,
  input  logic              aWrSel,
  input  logic              aEn,
  input  logic              aMbSel,
  input  logic [DATA_W-1:0] aData,
  input  logic              bCsN,
  input  logic              bWrSel,
  input  logic              bEn,
  input  logic              bMbSel,
  output logic [DATA_W-1:0] bData,
  output logic              bDataOe,
  output logic              fullN,
  output logic              almostFullN,
  output logic              emptyN,
  output logic              almostEmptyN
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [PTR_W-1:0]  wrLevel, rdLevel;

  dual_clock_fifo_ctrl #(
    .DEPTH(DEPTH), .SEL_W(SEL_W), .OFFSET_STEP(OFFSET_STEP)
  ) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .flagSel(flagSel),
    .aCsN(aCsN), .aWrSel(aWrSel), .aEn(aEn), .aMbSel(aMbSel),
    .bCsN(bCsN), .bWrSel(bWrSel), .bEn(bEn), .bMbSel(bMbSel),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrLevel(wrLevel), .rdLevel(rdLevel),
    .fullN(fullN), .almostFullN(almostFullN),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  dual_clock_fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(aData), .rdData(bData)
  );

  assign bDataOe = !bCsN && !bWrSel;

endmodule

// File: rtl/dual_clock_fifo_chk.sv
module dual_clock_fifo_chk
  import dual_clock_fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH) + 1
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input fifoStrobes_t      strobes,
  input logic [PTR_W-1:0]  wrLevel,
  input logic [PTR_W-1:0]  rdLevel,
  input logic [DATA_W-1:0] bData,
  input logic              fullN,
  input logic              almostFullN,
  input logic              emptyN,
  input logic              almostEmptyN
);

  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!rstN)
    wrLevel <= PTR_W'(DEPTH)); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (!rstN)
    rdLevel <= PTR_W'(DEPTH)); // R8

  AST_WR_LEVEL_ONLY_BY_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    !strobes.wrStrobe |=> wrLevel <= $past(wrLevel)); // R4

  AST_RD_LEVEL_ONLY_BY_READ: assert property (@(posedge rdClk) disable iff (!rstN)
    !strobes.rdStrobe |=> rdLevel >= $past(rdLevel)); // R5

  AST_RD_DATA_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    !strobes.rdStrobe |=> $stable(bData)); // R5

  AST_FULL_RELEASE_DELAY: assert property (@(posedge wrClk) disable iff (!rstN)
    fullN |-> $past(rstN, 2)); // R2

  AST_FULL_IMPLIES_AF: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrLevel == PTR_W'(DEPTH)) |-> (!fullN && !almostFullN)); // R9

  AST_EMPTY_IMPLIES_AE: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN); // R10

endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobes(strobes),
  .wrLevel(wrLevel), .rdLevel(rdLevel), .bData(bData),
  .fullN(fullN), .almostFullN(almostFullN),
  .emptyN(emptyN), .almostEmptyN(almostEmptyN)
);

// File: tb/dual_clock_fifo_tb.sv
module dual_clock_fifo_tb;

  localparam int DW = 36;
  localparam int DEPTH = 64;

  logic wrClk = 1'b0, rdClk = 1'b0, rstN = 1'b0;
  logic [1:0] flagSel = 2'b00;
  logic aCsN = 1'b1, aWrSel = 1'b0, aEn = 1'b0, aMbSel = 1'b0;
  logic [DW-1:0] aData = '0;
  logic bCsN = 1'b1, bWrSel = 1'b1, bEn = 1'b0, bMbSel = 1'b0;
  logic [DW-1:0] bData;
  logic bDataOe, fullN, almostFullN, emptyN, almostEmptyN;

  int checkCount = 0;
  int failCount = 0;

  always #2 wrClk = ~wrClk;   // 250 MHz
  always #3 rdClk = ~rdClk;

  dual_clock_fifo u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .flagSel(flagSel),
    .aCsN(aCsN), .aWrSel(aWrSel), .aEn(aEn), .aMbSel(aMbSel), .aData(aData),
    .bCsN(bCsN), .bWrSel(bWrSel), .bEn(bEn), .bMbSel(bMbSel),
    .bData(bData), .bDataOe(bDataOe), .fullN(fullN), .almostFullN(almostFullN),
    .emptyN(emptyN), .almostEmptyN(almostEmptyN)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pattern(input int code, input int idx);
    logic [31:0] mix = 32'(idx) * 32'h9E3779B1 ^ 32'(code * 1013);
    return {4'(code), mix};
  endfunction

  task automatic wrIdle();
    aCsN = 1'b1; aWrSel = 1'b0; aEn = 1'b0; aMbSel = 1'b0;
  endtask

  task automatic rdIdle();
    bCsN = 1'b1; bWrSel = 1'b1; bEn = 1'b0; bMbSel = 1'b0;
  endtask

  task automatic wrCycle(input logic cs, input logic dir, input logic en,
                         input logic mb, input logic [DW-1:0] d);
    @(negedge wrClk);
    aCsN = cs; aWrSel = dir; aEn = en; aMbSel = mb; aData = d;
    @(negedge wrClk);
    wrIdle();
  endtask

  task automatic rdCycle(input logic cs, input logic dir, input logic en, input logic mb);
    @(negedge rdClk);
    bCsN = cs; bWrSel = dir; bEn = en; bMbSel = mb;
    @(negedge rdClk);
    rdIdle();
  endtask

  task automatic runCode(input int code);
    int off = 4 * (code + 1);
    logic [DW-1:0] lastRead;
    // reset with this code selected
    @(negedge wrClk);
    rstN = 1'b0;
    flagSel = 2'(code);
    wrIdle(); rdIdle();
    repeat (5) @(negedge rdClk);
    repeat (2) @(negedge wrClk);
    check(fullN == 1'b0 && emptyN == 1'b0 && almostEmptyN == 1'b0 && almostFullN == 1'b1,
          "R1 flags in reset", {fullN, emptyN, almostEmptyN, almostFullN}, 36'b0001);
    check(bData == '0, "R1 bData in reset", bData, '0);
    rstN = 1'b1;                 // on falling wrClk edge
    #1 flagSel = ~2'(code);      // later changes must be ignored (R3)
    @(negedge wrClk);
    check(fullN == 1'b0, "R2 fullN after first edge", fullN, 0);
    @(negedge wrClk);
    check(fullN == 1'b1, "R2 fullN after second edge", fullN, 1);
    check(almostFullN == 1'b1, "R9 almostFullN empty buffer", almostFullN, 1);
    @(negedge rdClk);
    check(emptyN == 1'b0 && almostEmptyN == 1'b0, "R8 R10 read flags at start",
          {emptyN, almostEmptyN}, 0);
    // fill
    for (int n = 1; n <= DEPTH; n++) begin
      wrCycle(1'b0, 1'b1, 1'b1, 1'b0, pattern(code, n));
      check(fullN == (n != DEPTH), "R7 fullN level", fullN, (n != DEPTH));
      check(almostFullN == ((DEPTH - n) > off), "R3 R9 almostFullN level",
            almostFullN, ((DEPTH - n) > off));
      if (n == 10) begin
        // R4: each disqualifying condition stores nothing
        wrCycle(1'b1, 1'b1, 1'b1, 1'b0, 36'hBAD000001);
        wrCycle(1'b0, 1'b0, 1'b1, 1'b0, 36'hBAD000002);
        wrCycle(1'b0, 1'b1, 1'b0, 1'b0, 36'hBAD000003);
        wrCycle(1'b0, 1'b1, 1'b1, 1'b1, 36'hBAD000004);
        check(almostFullN == ((DEPTH - n) > off) && fullN == 1'b1,
              "R4 flags after disqualified writes", {fullN, almostFullN},
              {1'b1, ((DEPTH - n) > off)});
      end
    end
    wrCycle(1'b0, 1'b1, 1'b1, 1'b0, 36'hBAD0000FF);   // R7 write while full
    check(fullN == 1'b0, "R7 still full after extra write", fullN, 0);
    // let read side see the fill
    repeat (5) @(negedge rdClk);
    check(emptyN == 1'b1 && almostEmptyN == 1'b1, "R8 R10 read flags when full",
          {emptyN, almostEmptyN}, 2'b11);
    lastRead = bData;
    for (int k = 1; k <= DEPTH; k++) begin
      rdCycle(1'b0, 1'b0, 1'b1, 1'b0);
      lastRead = pattern(code, k);
      check(bData == lastRead, "R5 R6 data order", bData, lastRead);
      check(emptyN == ((DEPTH - k) != 0), "R8 emptyN level", emptyN, ((DEPTH - k) != 0));
      check(almostEmptyN == ((DEPTH - k) > off), "R3 R10 almostEmptyN level",
            almostEmptyN, ((DEPTH - k) > off));
      if (k == 20) begin
        rdCycle(1'b1, 1'b0, 1'b1, 1'b0);
        rdCycle(1'b0, 1'b1, 1'b1, 1'b0);
        rdCycle(1'b0, 1'b0, 1'b0, 1'b0);
        rdCycle(1'b0, 1'b0, 1'b1, 1'b1);
        check(bData == lastRead, "R5 bData held on disqualified reads", bData, lastRead);
      end
    end
    rdCycle(1'b0, 1'b0, 1'b1, 1'b0);   // R8 read while empty
    check(bData == lastRead, "R8 bData held on empty read", bData, lastRead);
    check(emptyN == 1'b0, "R8 still empty", emptyN, 0);
    repeat (5) @(negedge wrClk);
    check(fullN == 1'b1 && almostFullN == 1'b1, "R7 R9 write flags after drain",
          {fullN, almostFullN}, 2'b11);
  endtask

  initial begin
    #1000000;
    failCount++;
    checkCount++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    // R11 output enable, all four select/direction combinations
    for (int c = 0; c < 4; c++) begin
      bCsN = c[1]; bWrSel = c[0];
      #1;
      check(bDataOe == (c == 0), "R11 bDataOe", bDataOe, (c == 0));
    end
    rdIdle();
    for (int code = 0; code < 4; code++) runCode(code);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule